// File: doc/BRIEF.md
# Interrupt Dispatch and Halt Sequencer

This block sits next to an 8-bit processor core and decides what the core does at every instruction boundary. It can let the core fetch normally, keep the core asleep, wake it, or take over the bus for an interrupt entry. The block holds the interrupt master enable and a one-instruction delayed-enable latch.

The core signals each boundary with `step_i`. It also passes on single-cycle strobes for the four control instructions it decodes: halt, enable interrupts, disable interrupts and return from interrupt. An external arbiter supplies the highest-priority pending request as an index and a valid flag.

When an interrupt is taken, the sequencer does the following:
- It pushes the current PC onto the stack.
- It loads the new PC with the vector of the serviced source.
- It pulses an acknowledge back to the arbiter.
- It idles for the rest of the entry.

A halt instruction is treated in one of three ways, depending on the master enable and on pending requests. A variant input adds one extra wake-up cycle for the colour flavour of the core.

Top module: `intr_halt_seq`

## Requirements
- R1: After reset, and also when reset is applied while halted, `ime_o`, `halted_o`, `busy_o` and `pc_hold_o` are 0, and `fetch_go_o` is 0 while `step_i` is 0.
- R2: An enable strobe (`op_ei_i`) does not change `ime_o` immediately. At the next boundary, a pending request is not dispatched: `fetch_go_o` is 1 in that cycle. `ime_o` reads 1 from the following cycle.
- R3: A disable strobe makes `ime_o` 0 in the next cycle. A return-from-interrupt strobe makes `ime_o` 1 in the next cycle, so the next boundary with a request pending dispatches it.
- R4: At a boundary where `ime_o` is 1 and `irq_valid_i` is 1, `fetch_go_o` stays 0 and the entry starts. In the first entry cycle, the PC high byte is written at SP-1 and `ime_o` is 0. In the second entry cycle, the PC low byte is written at SP-2, and `sp_load_o`/`sp_new_o` report SP-2.
- R5: An interrupt entry keeps `busy_o` at 1 for exactly five cycles: two push cycles and three idle cycles. Exactly one acknowledge is issued.
- R6: In the second push cycle, `pc_load_o` is 1 and `pc_new_o` = 0x40 + 8 × `irq_idx_i`. The valid indices are 0 to 4, giving the vectors 0x40, 0x48, 0x50, 0x58 and 0x60. `irq_ack_o` is 1 and `irq_ack_idx_o` equals the index.
- R7: If `irq_valid_i` is 0 in the second push cycle, `pc_new_o` is 0x0000 and `irq_ack_o` is 0.
- R8: A halt strobe while `ime_o` is 0 and a request is pending does not halt. Instead, the next fetch has `pc_hold_o` 1, and the fetch after that has `pc_hold_o` 0.
- R9: A halt strobe while `ime_o` is 0 and nothing is pending sets `halted_o`. While halted, `step_i` is ignored and no fetch or stack write occurs. The block wakes once any request is valid; for the plain variant, the cycle after the request is seen gives a `fetch_go_o` without a dispatch.
- R10: A halt strobe while `ime_o` is 1 halts. When a request then appears, the wake-up boundary dispatches it and pushes the PC.
- R11: With `variant_color_i` = 1, waking from halt takes one extra busy cycle before the wake-up boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Core is at an instruction boundary |
| irq_valid_i | input | 1 | A request is pending |
| irq_idx_i | input | 3 | Index of the highest-priority pending request |
| op_halt_i | input | 1 | Halt instruction decoded |
| op_ei_i | input | 1 | Enable-interrupts instruction decoded |
| op_di_i | input | 1 | Disable-interrupts instruction decoded |
| op_reti_i | input | 1 | Return-from-interrupt decoded |
| pc_i | input | 16 | Current PC of the core |
| sp_i | input | 16 | Current SP of the core |
| variant_color_i | input | 1 | 1 selects the variant with the extra wake cycle |
| fetch_go_o | output | 1 | Core may fetch the next opcode |
| pc_hold_o | output | 1 | Do not advance the PC on this fetch |
| busy_o | output | 1 | Sequencer owns this cycle |
| halted_o | output | 1 | Core is halted |
| ime_o | output | 1 | Interrupt master enable |
| stk_we_o | output | 1 | Stack write request |
| stk_addr_o | output | 16 | Stack write address |
| stk_data_o | output | 8 | Stack write data |
| sp_load_o | output | 1 | Load SP with `sp_new_o` |
| sp_new_o | output | 16 | New SP after the push |
| pc_load_o | output | 1 | Load PC with `pc_new_o` |
| pc_new_o | output | 16 | Vector, or 0x0000 |
| irq_ack_o | output | 1 | Clear the serviced request |
| irq_ack_idx_o | output | 3 | Index being acknowledged |

## Verification
A wrong master enable or delayed-enable latch shows up at the first boundary with a request pending. In that cycle, `fetch_go_o` takes the wrong value, and `ime_o` differs one cycle later. A stuck or mis-stepped sequencer state shows up as a `busy_o` run of the wrong length after a dispatch, or as a misplaced push byte or address within two cycles. It also shows up as a wake-up fetch that comes one cycle early or late for the selected variant. A lost halt-bug flag is seen on the very next fetch as a missing `pc_hold_o`, and a flag that is never cleared is seen on the fetch after that.

// File: rtl/intr_halt_pkg.sv
`timescale 1ns/1ps
package intr_halt_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_WAKE,
        ST_EVAL,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_IDLE
    } seq_st_e;

    typedef enum logic [1:0] {
        HK_SERVICE,
        HK_SLEEP,
        HK_REPEAT
    } halt_kind_e;
endpackage

// File: rtl/isr_vec_calc.sv
`timescale 1ns/1ps
module isr_vec_calc #(
    parameter int AW     = 16,
    parameter int IDX_W  = 3,
    parameter int BASE   = 'h40,
    parameter int STRIDE = 8
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             live_i,
    output logic [AW-1:0]    vec_o
);
    always_comb begin
        if (live_i) begin
            vec_o = AW'(BASE) + AW'(idx_i) * AW'(STRIDE);
        end else begin
            vec_o = '0;
        end
    end
endmodule

// File: rtl/halt_entry_sel.sv
`timescale 1ns/1ps
module halt_entry_sel
    import intr_halt_pkg::*;
(
    input  logic       ime_i,
    input  logic       pend_i,
    output halt_kind_e kind_o
);
    always_comb begin
        if (ime_i) begin
            kind_o = HK_SERVICE;
        end else if (pend_i) begin
            kind_o = HK_REPEAT;
        end else begin
            kind_o = HK_SLEEP;
        end
    end
endmodule

// File: rtl/push_frame.sv
`timescale 1ns/1ps
module push_frame #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          lo_phase_i,
    input  logic [AW-1:0] sp_i,
    input  logic [AW-1:0] pc_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    localparam int HI_BYTE = AW / DW - 1;

    always_comb begin
        if (lo_phase_i) begin
            addr_o = sp_i - AW'(2);
            data_o = pc_i[DW-1:0];
        end else begin
            addr_o = sp_i - AW'(1);
            data_o = pc_i[HI_BYTE*DW +: DW];
        end
    end
endmodule

// File: rtl/intr_halt_seq.sv
`timescale 1ns/1ps
module intr_halt_seq
    import intr_halt_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int IDX_W       = 3,
    parameter int VEC_BASE    = 'h40,
    parameter int VEC_STRIDE  = 8,
    parameter int IDLE_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             irq_valid_i,
    input  logic [IDX_W-1:0] irq_idx_i,
    input  logic             op_halt_i,
    input  logic             op_ei_i,
    input  logic             op_di_i,
    input  logic             op_reti_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    sp_i,
    input  logic             variant_color_i,
    output logic             fetch_go_o,
    output logic             pc_hold_o,
    output logic             busy_o,
    output logic             halted_o,
    output logic             ime_o,
    output logic             stk_we_o,
    output logic [AW-1:0]    stk_addr_o,
    output logic [DW-1:0]    stk_data_o,
    output logic             sp_load_o,
    output logic [AW-1:0]    sp_new_o,
    output logic             pc_load_o,
    output logic [AW-1:0]    pc_new_o,
    output logic             irq_ack_o,
    output logic [IDX_W-1:0] irq_ack_idx_o
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        seq_st_e          st;
        logic             ime;
        logic             ei_pend;
        logic             bug;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    pc;
        logic [AW-1:0]    sp;
    } seq_t;

    seq_t q, d;

    logic       decide;
    logic       dispatch;
    logic       go;
    halt_kind_e hkind;
    logic       lo_phase;
    logic       ack_live;
    logic [AW-1:0] vec;
    logic [AW-1:0] frame_addr;
    logic [DW-1:0] frame_data;

    halt_entry_sel u_hsel (
        .ime_i  (q.ime),
        .pend_i (irq_valid_i),
        .kind_o (hkind)
    );

    assign lo_phase = (q.st == ST_PUSH_LO);
    assign ack_live = lo_phase && irq_valid_i;

    isr_vec_calc #(
        .AW     (AW),
        .IDX_W  (IDX_W),
        .BASE   (VEC_BASE),
        .STRIDE (VEC_STRIDE)
    ) u_vec (
        .idx_i  (irq_idx_i),
        .live_i (irq_valid_i),
        .vec_o  (vec)
    );

    push_frame #(
        .AW (AW),
        .DW (DW)
    ) u_frame (
        .lo_phase_i (lo_phase),
        .sp_i       (q.sp),
        .pc_i       (q.pc),
        .addr_o     (frame_addr),
        .data_o     (frame_data)
    );

    assign decide   = ((q.st == ST_RUN) && step_i) || (q.st == ST_EVAL);
    assign dispatch = decide && q.ime && irq_valid_i;
    assign go       = decide && !dispatch;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_RUN, ST_EVAL: begin
                if (dispatch) begin
                    d.st  = ST_PUSH_HI;
                    d.pc  = pc_i;
                    d.sp  = sp_i;
                    d.ime = 1'b0;
                end else begin
                    d.st = ST_RUN;
                    if (go) begin
                        d.bug = 1'b0;
                        if (q.ei_pend) begin
                            d.ime     = 1'b1;
                            d.ei_pend = 1'b0;
                        end
                    end
                    if (q.st == ST_RUN) begin
                        if (op_ei_i) begin
                            d.ei_pend = 1'b1;
                        end
                        if (op_di_i) begin
                            d.ime = 1'b0;
                        end
                        if (op_reti_i) begin
                            d.ime = 1'b1;
                        end
                        if (op_halt_i) begin
                            if (hkind == HK_REPEAT) begin
                                d.bug = 1'b1;
                            end else begin
                                d.st = ST_HALT;
                            end
                        end
                    end
                end
            end
            ST_HALT: begin
                if (irq_valid_i) begin
                    d.st = variant_color_i ? ST_WAKE : ST_EVAL;
                end
            end
            ST_WAKE: begin
                d.st = ST_EVAL;
            end
            ST_PUSH_HI: begin
                d.st = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                d.st  = ST_IDLE;
                d.cnt = CNT_LOAD;
            end
            ST_IDLE: begin
                if (q.cnt == '0) begin
                    d.st = ST_RUN;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: begin
                d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, ime: 1'b0, ei_pend: 1'b0, bug: 1'b0,
                   cnt: '0, pc: '0, sp: '0};
        end else begin
            q <= d;
        end
    end

    assign fetch_go_o    = go;
    assign pc_hold_o     = go && q.bug;
    assign busy_o        = (q.st == ST_WAKE) || (q.st == ST_PUSH_HI) ||
                           (q.st == ST_PUSH_LO) || (q.st == ST_IDLE);
    assign halted_o      = (q.st == ST_HALT);
    assign ime_o         = q.ime;
    assign stk_we_o      = (q.st == ST_PUSH_HI) || lo_phase;
    assign stk_addr_o    = stk_we_o ? frame_addr : '0;
    assign stk_data_o    = stk_we_o ? frame_data : '0;
    assign sp_load_o     = lo_phase;
    assign sp_new_o      = lo_phase ? frame_addr : '0;
    assign pc_load_o     = lo_phase;
    assign pc_new_o      = lo_phase ? vec : '0;
    assign irq_ack_o     = ack_live;
    assign irq_ack_idx_o = ack_live ? irq_idx_i : '0;
endmodule

// File: rtl/intr_halt_seq_chk.sv
`timescale 1ns/1ps
module intr_halt_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_go_o,
    input logic          pc_hold_o,
    input logic          halted_o,
    input logic          ime_o,
    input logic          stk_we_o,
    input logic [AW-1:0] stk_addr_o,
    input logic          pc_load_o,
    input logic [AW-1:0] pc_new_o,
    input logic          irq_ack_o
);
    a_r4_push_order: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o && !pc_load_o) |=>
            (stk_we_o && pc_load_o && stk_addr_o == $past(stk_addr_o) - AW'(1)))
        else $error("R4 push order broken");

    a_r4_ime_off: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we_o |-> !ime_o)
        else $error("R4 enable not cleared during entry");

    a_r5_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o)
        else $error("R5 repeated acknowledge");

    a_r6_ack_loads: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |-> pc_load_o)
        else $error("R6 acknowledge without PC load");

    a_r7_zero_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !irq_ack_o) |-> (pc_new_o == '0))
        else $error("R7 vanished request not zero");

    a_r8_hold_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold_o |-> fetch_go_o)
        else $error("R8 hold outside fetch");

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!fetch_go_o && !stk_we_o))
        else $error("R9 activity while halted");
endmodule

bind intr_halt_seq intr_halt_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_go_o (fetch_go_o),
    .pc_hold_o  (pc_hold_o),
    .halted_o   (halted_o),
    .ime_o      (ime_o),
    .stk_we_o   (stk_we_o),
    .stk_addr_o (stk_addr_o),
    .pc_load_o  (pc_load_o),
    .pc_new_o   (pc_new_o),
    .irq_ack_o  (irq_ack_o)
);

// File: tb/intr_halt_seq_test.sv
`timescale 1ns/1ps
module intr_halt_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        irq_valid_i = 1'b0;
    logic [2:0]  irq_idx_i = '0;
    logic        op_halt_i = 1'b0;
    logic        op_ei_i = 1'b0;
    logic        op_di_i = 1'b0;
    logic        op_reti_i = 1'b0;
    logic [15:0] pc_i = 16'h0100;
    logic [15:0] sp_i = 16'hFFFE;
    logic        variant_color_i = 1'b0;
    logic        fetch_go_o, pc_hold_o, busy_o, halted_o, ime_o;
    logic        stk_we_o, sp_load_o, pc_load_o, irq_ack_o;
    logic [15:0] stk_addr_o, sp_new_o, pc_new_o;
    logic [7:0]  stk_data_o;
    logic [2:0]  irq_ack_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_halt_seq uut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .irq_valid_i(irq_valid_i),
        .irq_idx_i(irq_idx_i), .op_halt_i(op_halt_i), .op_ei_i(op_ei_i),
        .op_di_i(op_di_i), .op_reti_i(op_reti_i), .pc_i(pc_i), .sp_i(sp_i),
        .variant_color_i(variant_color_i), .fetch_go_o(fetch_go_o),
        .pc_hold_o(pc_hold_o), .busy_o(busy_o), .halted_o(halted_o),
        .ime_o(ime_o), .stk_we_o(stk_we_o), .stk_addr_o(stk_addr_o),
        .stk_data_o(stk_data_o), .sp_load_o(sp_load_o), .sp_new_o(sp_new_o),
        .pc_load_o(pc_load_o), .pc_new_o(pc_new_o), .irq_ack_o(irq_ack_o),
        .irq_ack_idx_o(irq_ack_idx_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        step_i = 1'b0; op_halt_i = 1'b0; op_ei_i = 1'b0;
        op_di_i = 1'b0; op_reti_i = 1'b0;
    endtask

    task automatic set_ime(input bit on);
        nxt();
        irq_valid_i = 1'b0;
        if (on) begin
            op_ei_i = 1'b1;
            nxt();
            step_i = 1'b1;
        end else begin
            op_di_i = 1'b1;
        end
        nxt();
    endtask

    task automatic wait_free();
        for (int k = 0; k < 20; k++) begin
            if (!busy_o && !halted_o) break;
            nxt();
            irq_valid_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        nxt();
        op_halt_i = 1'b1;
        nxt();
        #1 chk("R1 halted before reset", halted_o, 1);
        rst_n = 1'b0;
        #1;
        chk("R1 halted cleared", halted_o, 0);
        chk("R1 ime", ime_o, 0);
        chk("R1 busy", busy_o, 0);
        nxt();
        rst_n = 1'b1;
        nxt();
        #1;
        chk("R1 fetch idle", fetch_go_o, 0);
        chk("R1 hold", pc_hold_o, 0);
    endtask

    task automatic t_dispatch(input logic [2:0] idx);
        int nb;
        set_ime(1);
        chk("R3 ime set before entry", ime_o, 1);
        pc_i = 16'h1230 + 16'(idx); sp_i = 16'hC000;
        irq_valid_i = 1'b1; irq_idx_i = idx; step_i = 1'b1;
        #1 chk("R4 no fetch at dispatch", fetch_go_o, 0);
        nxt();
        #1;
        chk("R4 hi we", stk_we_o, 1);
        chk("R4 hi addr", stk_addr_o, 16'hBFFF);
        chk("R4 hi data", stk_data_o, 8'h12);
        chk("R4 ime cleared", ime_o, 0);
        nb = busy_o ? 1 : 0;
        nxt();
        #1;
        chk("R4 lo addr", stk_addr_o, 16'hBFFE);
        chk("R4 lo data", stk_data_o, 8'h30 + 8'(idx));
        chk("R4 sp new", sp_new_o, 16'hBFFE);
        chk("R6 pc load", pc_load_o, 1);
        chk("R6 vector", pc_new_o, 16'h40 + 16'(idx) * 16'd8);
        chk("R6 ack", irq_ack_o, 1);
        chk("R6 ack idx", irq_ack_idx_o, idx);
        if (busy_o) nb++;
        for (int k = 0; k < 20; k++) begin
            nxt();
            irq_valid_i = 1'b0;
            #1;
            if (!busy_o) break;
            nb++;
            chk("R5 idle no write", stk_we_o, 0);
        end
        chk("R5 busy length", nb, 5);
        step_i = 1'b1;
        #1 chk("R5 fetch after entry", fetch_go_o, 1);
        nxt();
    endtask

    task automatic t_vanish();
        set_ime(1);
        irq_valid_i = 1'b1; irq_idx_i = 3'd4; step_i = 1'b1;
        nxt();
        nxt();
        irq_valid_i = 1'b0;
        #1;
        chk("R7 pc load", pc_load_o, 1);
        chk("R7 zero pc", pc_new_o, 16'h0000);
        chk("R7 no ack", irq_ack_o, 0);
        wait_free();
    endtask

    task automatic t_ei_delay();
        set_ime(0);
        op_ei_i = 1'b1;
        #1 chk("R2 ime not yet", ime_o, 0);
        nxt();
        irq_valid_i = 1'b1; irq_idx_i = 3'd1; step_i = 1'b1;
        #1 chk("R2 fetch instead of dispatch", fetch_go_o, 1);
        nxt();
        #1 chk("R2 ime after boundary", ime_o, 1);
        step_i = 1'b1;
        #1 chk("R2 dispatch at next boundary", fetch_go_o, 0);
        nxt();
        wait_free();
    endtask

    task automatic t_di_reti();
        set_ime(1);
        op_di_i = 1'b1;
        nxt();
        #1 chk("R3 di clears", ime_o, 0);
        op_reti_i = 1'b1;
        nxt();
        #1 chk("R3 reti sets", ime_o, 1);
        irq_valid_i = 1'b1; irq_idx_i = 3'd0; step_i = 1'b1;
        #1 chk("R3 reti allows dispatch", fetch_go_o, 0);
        nxt();
        wait_free();
    endtask

    task automatic t_halt_sleep(input bit color);
        variant_color_i = color;
        set_ime(0);
        op_halt_i = 1'b1;
        nxt();
        #1 chk("R9 halted", halted_o, 1);
        for (int k = 0; k < 12; k++) begin
            step_i = 1'b1;
            #1;
            chk("R9 step ignored", fetch_go_o, 0);
            chk("R9 halt kept", halted_o, 1);
            nxt();
        end
        irq_valid_i = 1'b1; irq_idx_i = 3'd2;
        nxt();
        #1;
        if (color) begin
            chk("R11 extra busy", busy_o, 1);
            chk("R11 no early fetch", fetch_go_o, 0);
            nxt();
            #1;
        end
        if (color) chk("R11 wake fetch", fetch_go_o, 1);
        else chk("R9 wake fetch", fetch_go_o, 1);
        chk("R9 no ack on wake", irq_ack_o, 0);
        nxt();
        irq_valid_i = 1'b0;
        #1 chk("R9 no entry", stk_we_o, 0);
        variant_color_i = 1'b0;
    endtask

    task automatic t_halt_service();
        set_ime(1);
        op_halt_i = 1'b1;
        nxt();
        #1 chk("R10 halted", halted_o, 1);
        nxt();
        irq_valid_i = 1'b1; irq_idx_i = 3'd1;
        nxt();
        #1 chk("R10 wake dispatches", fetch_go_o, 0);
        nxt();
        #1 chk("R10 push", stk_we_o, 1);
        nxt();
        #1 chk("R10 vector", pc_new_o, 16'h0048);
        wait_free();
    endtask

    task automatic t_halt_bug();
        set_ime(0);
        irq_valid_i = 1'b1; irq_idx_i = 3'd3;
        op_halt_i = 1'b1;
        nxt();
        #1 chk("R8 not halted", halted_o, 0);
        step_i = 1'b1;
        #1;
        chk("R8 fetch", fetch_go_o, 1);
        chk("R8 hold set", pc_hold_o, 1);
        nxt();
        step_i = 1'b1;
        #1 chk("R8 hold once", pc_hold_o, 0);
        nxt();
        irq_valid_i = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ime reset", ime_o, 0);
        chk("R1 halted reset", halted_o, 0);
        chk("R1 busy reset", busy_o, 0);
        rst_n = 1'b1;
        t_reset();
        t_dispatch(3'd2);
        t_dispatch(3'd0);
        t_dispatch(3'd4);
        t_vanish();
        t_ei_delay();
        t_di_reti();
        t_halt_sleep(1'b0);
        t_halt_sleep(1'b1);
        t_halt_service();
        t_halt_bug();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule